// File: doc/BRIEF.md
# Dual-Width Static RAM Front End

This block is a clocked front end for a small static RAM that works either as a 16-bit-wide array or as an 8-bit-wide array with twice as many locations. On every clock edge it samples two chip selects, two byte-lane enables, a write strobe, an output enable and a width-select input. From these it picks one of three modes: idle, read or write. It then performs the access on a byte-lane storage array built so that block RAM can be inferred.

The data pins are modelled as a three-state bus split into three signals: an input word `dq_in`, an output word `dq_out` and a per-bit drive enable `dq_oe`. In 8-bit mode the top data pin is not a data bit. It is sampled as the lowest address bit and picks the low byte (0) or the high byte (1) of the 16-bit word held at `addr`. Read data and drive enables appear one clock after the read is sampled. Undriven bits always read as zero on `dq_out`.

Top module: `dwsram_fe`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `dq_oe` and `dq_out` are all zero.
- R2: A cycle with `cs1_n`=1, or `cs2`=0, or both `lane_n` bits high is deselected: storage is not written, and in the following cycle `dq_oe` is all zero.
- R3: In 16-bit mode (`wide`=1), a selected cycle with `we_n`=0 writes `dq_in[7:0]` into the low byte only if `lane_n[0]`=0, and writes `dq_in[15:8]` into the high byte only if `lane_n[1]`=0.
- R4: In 16-bit mode, a selected cycle with `we_n`=1 and `oe_n`=0 is a read. In the next cycle each enabled lane drives its stored byte with its 8 `dq_oe` bits set. A disabled lane has `dq_oe` and `dq_out` zero.
- R5: A selected cycle with `we_n`=1 and `oe_n`=1 leaves `dq_oe` all zero in the next cycle.
- R6: A selected cycle with `we_n`=0 leaves `dq_oe` all zero in the next cycle, whatever `oe_n` is.
- R7: In 8-bit mode (`wide`=0), bit 15 of `dq_in` is an address bit: 0 selects the low byte and 1 the high byte of word `addr`. A write stores `dq_in[7:0]` into that byte. A read returns it on `dq_out[7:0]` with `dq_oe`=16'h00FF. Bits 15:8 are never driven in this mode.
- R8: In 8-bit mode, an access happens only when both `lane_n` bits are low. With either one high, nothing is written and `dq_oe` is zero in the next cycle.
- R9: A read in the cycle directly after a write to the same location returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| lane_n | input | 2 | Byte-lane enables, active low; bit 0 low byte, bit 1 high byte |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| wide | input | 1 | 1 selects 16-bit organization, 0 selects 8-bit |
| addr | input | ADDR_W | Word address |
| dq_in | input | 2*LANE_W | Data bus as seen entering the block; top bit is the byte address in 8-bit mode |
| dq_out | output | 2*LANE_W | Data the block drives onto the bus |
| dq_oe | output | 2*LANE_W | Per-bit drive enable for `dq_out` |

## Verification
The bench overrides `ADDR_W` to 4, so the array has 16 words. The whole array can then be filled, read back and revisited many times within a short random run, and byte-mode accesses hit both halves of every word. `LANE_W` stays at 8, which keeps the top data pin as the byte-address bit exactly as in normal use. With this small depth, random traffic that mixes widths, selects and strobes reaches every combination of write-then-read, lane masking and width switching on the same locations.

// File: rtl/dwsram_pkg.sv
package dwsram_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_READ  = 2'd1,
    MODE_WRITE = 2'd2
  } mode_e;
endpackage

// File: rtl/dwsram_decode.sv
module dwsram_decode
  import dwsram_pkg::*;
(
  input  logic       cs1_n,
  input  logic       cs2,
  input  logic [1:0] lane_n,
  input  logic       we_n,
  input  logic       oe_n,
  input  logic       wide,
  input  logic       a_lsb,
  output logic [1:0] lane_wr,
  output logic [1:0] lane_rd
);
  logic  chip_on;
  logic  active;
  logic [1:0] lane_sel;
  mode_e mode;

  always_comb begin
    chip_on = !cs1_n && cs2;
    // 16-bit needs one lane, 8-bit needs both lanes enabled
    if (wide) active = chip_on && (lane_n != 2'b11);
    else      active = chip_on && (lane_n == 2'b00);

    if (!active)    mode = MODE_IDLE;
    else if (!we_n) mode = MODE_WRITE;
    else if (!oe_n) mode = MODE_READ;
    else            mode = MODE_IDLE;

    if (wide) lane_sel = ~lane_n;
    else      lane_sel = a_lsb ? 2'b10 : 2'b01;

    lane_wr = (mode == MODE_WRITE) ? lane_sel : 2'b00;
    lane_rd = (mode == MODE_READ)  ? lane_sel : 2'b00;
  end
endmodule

// File: rtl/dwsram_lanes.sv
module dwsram_lanes #(
  parameter int LANE_W = 8,
  parameter int ADDR_W = 8,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES-1:0]          wr_en,
  input  logic [LANES*LANE_W-1:0]   wr_data,
  output logic [LANES*LANE_W-1:0]   rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (wr_en[g]) mem[addr] <= wr_data[g*LANE_W +: LANE_W];
      rd_q <= mem[addr];
    end

    assign rd_data[g*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/dwsram_steer.sv
module dwsram_steer #(
  parameter int LANE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            lane_rd,
  input  logic                  wide,
  input  logic [2*LANE_W-1:0]   lane_data,
  output logic [2*LANE_W-1:0]   dq_out,
  output logic [2*LANE_W-1:0]   dq_oe
);
  localparam int DATA_W = 2 * LANE_W;

  logic [1:0] rd_q;
  logic       wide_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= 2'b00;
      wide_q <= 1'b1;
    end else begin
      rd_q   <= lane_rd;
      wide_q <= wide;
    end
  end

  logic [LANE_W-1:0] lo_b, hi_b;
  assign lo_b = lane_data[LANE_W-1:0];
  assign hi_b = lane_data[DATA_W-1:LANE_W];

  always_comb begin
    dq_oe  = '0;
    dq_out = '0;
    if (wide_q) begin
      dq_oe  = {{LANE_W{rd_q[1]}}, {LANE_W{rd_q[0]}}};
      dq_out = lane_data & dq_oe;
    end else if (rd_q != 2'b00) begin
      dq_oe[LANE_W-1:0]  = '1;
      dq_out[LANE_W-1:0] = rd_q[1] ? hi_b : lo_b;
    end
  end
endmodule

// File: rtl/dwsram_fe.sv
module dwsram_fe #(
  parameter int LANE_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cs1_n,
  input  logic                  cs2,
  input  logic [1:0]            lane_n,
  input  logic                  we_n,
  input  logic                  oe_n,
  input  logic                  wide,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [2*LANE_W-1:0]   dq_in,
  output logic [2*LANE_W-1:0]   dq_out,
  output logic [2*LANE_W-1:0]   dq_oe
);
  localparam int DATA_W = 2 * LANE_W;

  logic [1:0]        lane_wr, lane_rd;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic              a_lsb;

  // top pin becomes the byte address in narrow mode
  assign a_lsb = dq_in[DATA_W-1];

  assign wr_data[LANE_W-1:0]      = dq_in[LANE_W-1:0];
  assign wr_data[DATA_W-1:LANE_W] = wide ? dq_in[DATA_W-1:LANE_W] : dq_in[LANE_W-1:0];

  dwsram_decode u_decode (
    .cs1_n   (cs1_n),
    .cs2     (cs2),
    .lane_n  (lane_n),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .wide    (wide),
    .a_lsb   (a_lsb),
    .lane_wr (lane_wr),
    .lane_rd (lane_rd)
  );

  dwsram_lanes #(.LANE_W(LANE_W), .ADDR_W(ADDR_W), .LANES(2)) u_lanes (
    .clk     (clk),
    .addr    (addr),
    .wr_en   (lane_wr),
    .wr_data (wr_data),
    .rd_data (rd_data)
  );

  dwsram_steer #(.LANE_W(LANE_W)) u_steer (
    .clk       (clk),
    .rst       (rst),
    .lane_rd   (lane_rd),
    .wide      (wide),
    .lane_data (rd_data),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe)
  );
endmodule

// File: rtl/dwsram_fe_chk.sv
module dwsram_fe_chk #(
  parameter int LANE_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                cs1_n,
  input logic                cs2,
  input logic [1:0]          lane_n,
  input logic                we_n,
  input logic                oe_n,
  input logic                wide,
  input logic [2*LANE_W-1:0] dq_out,
  input logic [2*LANE_W-1:0] dq_oe
);
  logic chip_on;
  assign chip_on = !cs1_n && cs2 && (lane_n != 2'b11);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (dq_oe == '0 && dq_out == '0));

  // R2
  deselect_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    !chip_on |=> dq_oe == '0);

  // R5
  no_oe_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    (chip_on && we_n && oe_n) |=> dq_oe == '0);

  // R6
  write_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    !we_n |=> dq_oe == '0);

  // R7
  narrow_upper_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    !wide |=> dq_oe[2*LANE_W-1:LANE_W] == '0);

  // R8
  narrow_lane_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!wide && lane_n != 2'b00) |=> dq_oe == '0);

  // R4
  undriven_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (dq_out & ~dq_oe) == '0);

  // R4
  wide_lane_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (wide && lane_n[0]) |=> dq_oe[LANE_W-1:0] == '0);
endmodule

bind dwsram_fe dwsram_fe_chk #(.LANE_W(LANE_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .cs1_n  (cs1_n),
  .cs2    (cs2),
  .lane_n (lane_n),
  .we_n   (we_n),
  .oe_n   (oe_n),
  .wide   (wide),
  .dq_out (dq_out),
  .dq_oe  (dq_oe)
);

// File: tb/dwsram_fe_bench.sv
module dwsram_fe_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs1_n = 1'b1, cs2 = 1'b0, we_n = 1'b1, oe_n = 1'b1, wide = 1'b1;
  logic [1:0]    lane_n = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [15:0]   dq_in = '0;
  logic [15:0]   dq_out, dq_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0]  m_lo [DEPTH];
  logic [7:0]  m_hi [DEPTH];
  logic [15:0] exp_out, exp_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  dwsram_fe #(.LANE_W(8), .ADDR_W(AW)) u_dwsram_fe (
    .clk(clk), .rst(rst), .cs1_n(cs1_n), .cs2(cs2), .lane_n(lane_n),
    .we_n(we_n), .oe_n(oe_n), .wide(wide), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic check(input string tag);
    checks++;
    if (dq_out !== exp_out || dq_oe !== exp_oe) begin
      fails++;
      $display("FAIL %s: out=%h oe=%h expected out=%h oe=%h", tag, dq_out, dq_oe, exp_out, exp_oe);
    end
  endtask

  // one clock: drive at negedge, model, compare at next negedge
  task automatic cyc(input logic c1n, input logic c2, input logic [1:0] ln,
                     input logic wn, input logic on, input logic w16,
                     input logic [AW-1:0] a, input logic [15:0] d, input string tag_in);
    bit sel;
    string tag;
    cs1_n = c1n; cs2 = c2; lane_n = ln; we_n = wn; oe_n = on; wide = w16;
    addr = a; dq_in = d;
    sel = !c1n && c2 && (w16 ? (ln != 2'b11) : (ln == 2'b00));
    exp_out = '0; exp_oe = '0;
    if (!c1n && c2 && ln != 2'b11 && !sel) tag = "R8";
    else if (!sel) tag = "R2";
    else if (!wn) tag = "R6";
    else if (on) tag = "R5";
    else if (!w16) tag = "R7";
    else tag = "R4";
    if (tag_in != "") tag = tag_in;
    if (sel && !wn) begin
      if (w16) begin
        if (!ln[0]) m_lo[a] = d[7:0];
        if (!ln[1]) m_hi[a] = d[15:8];
      end else if (d[15]) m_hi[a] = d[7:0];
      else m_lo[a] = d[7:0];
    end else if (sel && !on) begin
      if (w16) begin
        if (!ln[0]) begin exp_out[7:0]  = m_lo[a]; exp_oe[7:0]  = 8'hFF; end
        if (!ln[1]) begin exp_out[15:8] = m_hi[a]; exp_oe[15:8] = 8'hFF; end
      end else begin
        exp_out[7:0] = d[15] ? m_hi[a] : m_lo[a];
        exp_oe[7:0]  = 8'hFF;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle();
    cyc(1'b1, 1'b0, 2'b11, 1'b1, 1'b1, 1'b1, '0, '0, "R2");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: out=%h oe=%h expected out=%h oe=%h", dq_out, dq_oe, exp_out, exp_oe);
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    exp_out = '0; exp_oe = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1");
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1");

    // R3: fill full words
    for (int i = 0; i < DEPTH; i++)
      cyc(1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 1'b1, AW'(i), 16'(i * 16'h1357 + 16'h0A0B), "R3");
    // R4: read back all
    for (int i = 0; i < DEPTH; i++)
      cyc(1'b0, 1'b1, 2'b00, 1'b1, 1'b0, 1'b1, AW'(i), '0, "R4");
    // R3: single-lane writes, then full reads
    cyc(1'b0, 1'b1, 2'b10, 1'b0, 1'b0, 1'b1, 4'd3, 16'hAA55, "R6");
    cyc(1'b0, 1'b1, 2'b01, 1'b0, 1'b1, 1'b1, 4'd4, 16'hC33C, "R3");
    cyc(1'b0, 1'b1, 2'b00, 1'b1, 1'b0, 1'b1, 4'd3, '0, "R3");
    cyc(1'b0, 1'b1, 2'b00, 1'b1, 1'b0, 1'b1, 4'd4, '0, "R3");
    // R4: single-lane reads
    cyc(1'b0, 1'b1, 2'b10, 1'b1, 1'b0, 1'b1, 4'd5, '0, "R4");
    cyc(1'b0, 1'b1, 2'b01, 1'b1, 1'b0, 1'b1, 4'd5, '0, "R4");
    // R2: blocked writes, then readback
    cyc(1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 4'd6, 16'hDEAD, "R2");
    cyc(1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 4'd6, 16'hBEEF, "R2");
    cyc(1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 1'b1, 4'd6, 16'hF00D, "R2");
    cyc(1'b0, 1'b1, 2'b00, 1'b1, 1'b0, 1'b1, 4'd6, '0, "R2");
    // R5
    cyc(1'b0, 1'b1, 2'b00, 1'b1, 1'b1, 1'b1, 4'd6, '0, "R5");
    // R9: write then immediate read
    cyc(1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 1'b1, 4'd7, 16'h1234, "R9");
    cyc(1'b0, 1'b1, 2'b00, 1'b1, 1'b0, 1'b1, 4'd7, '0, "R9");
    // R7: byte mode, both halves
    cyc(1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 4'd8, 16'h0077, "R7");
    cyc(1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 4'd8, 16'h8099, "R7");
    cyc(1'b0, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 4'd8, 16'h0000, "R7");
    cyc(1'b0, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 4'd8, 16'h8000, "R7");
    cyc(1'b0, 1'b1, 2'b00, 1'b1, 1'b0, 1'b1, 4'd8, '0, "R7");
    // R8: byte mode with one lane off
    cyc(1'b0, 1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 4'd9, 16'h0011, "R8");
    cyc(1'b0, 1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 4'd9, 16'h8022, "R8");
    cyc(1'b0, 1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 4'd9, 16'h0000, "R8");
    cyc(1'b0, 1'b1, 2'b00, 1'b1, 1'b0, 1'b1, 4'd9, '0, "R8");
    idle();

    // random traffic over all input combinations
    for (int n = 0; n < 1500; n++) begin
      logic c1n, c2, wn, on, w16;
      logic [1:0] ln;
      c1n = ($urandom % 6) == 0;
      c2  = ($urandom % 6) != 0;
      ln  = 2'($urandom);
      if (($urandom % 3) == 0) ln = 2'b00;
      wn  = ($urandom % 3) == 0;
      on  = ($urandom % 4) == 0;
      w16 = ($urandom % 2) == 0;
      cyc(c1n, c2, ln, wn, on, w16, AW'($urandom), 16'($urandom), "");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule